// File: doc/BRIEF.md
# Peripheral Chip-Select and Register-Index Decoder

This block sits beside a combined ROM, RAM and I/O peripheral on a shared 8-bit processor bus. From the low ten address lines, an active-low ROM-select pin, an active-low chip-select pin, the read/write line and the bus clock phase, it produces one select per internal resource. It also produces the re-mapped address and control lines for a substitute I/O device whose register layout differs from the original part.

The decode leaves a hole wherever A6 is high. A partially decoded interface adapter shares the same chip-select line and owns that range. RAM (64 bytes) answers in page zero and again in page one, which gives the processor a stack. ROM drive is held off during the low clock phase, when a second processor on the opposite phase owns the common data bus. ROM drive is also held off on writes, so a stray store cannot cause a bus fight.

Two parameters select mask-style variants. `RAM_USE_A9` decides whether A9 takes part in the RAM decode. `IO_FULL_DECODE` chooses between exact I/O decoding and decoding with mirrors.

Top module: `periph_addr_decoder`

## Requirements
- R1: `rom_en` is 1 exactly when `rom_sel_n`=0, `cs_n`=1 and `rd_wr_n`=1 (read). It does not depend on `addr` or `phi2`.
- R2: `rom_oe` is 1 exactly when `rom_en` is 1 and `phi2` is 1.
- R3: With `rd_wr_n`=0 (write), `rom_en` and `rom_oe` are both 0 for every address and pin combination.
- R4: With `RAM_USE_A9`=1, `ram_sel` is 1 exactly when `rom_sel_n`=1, `cs_n`=0 and `addr` lies in 0x000–0x03F or 0x100–0x13F.
- R5: With `RAM_USE_A9`=0, `ram_sel` also answers at 0x200–0x23F and 0x300–0x33F, under the same pin conditions as R4.
- R6: With `IO_FULL_DECODE`=1, `io_sel` is 1 exactly when `cs_n`=0 and `addr` lies in 0x080–0x08F.
- R7: With `IO_FULL_DECODE`=0, `io_sel` is 1 exactly when `cs_n`=0 and `addr` lies in 0x080–0x0BF.
- R8: When `addr[6]`=1, neither `ram_sel` nor `io_sel` is 1. This covers 0x040–0x07F, its mirrors and 0x1FF.
- R9: At most one of `rom_en`, `ram_sel` and `io_sel` is 1 at any time.
- R10: `xlat_addr` (bits 6..0) equals {0, A5, A4 OR A7, A3, A2, A1, A0}. `xlat_cs_hi` equals NOT A6. `xlat_io_mode` equals A7, where 1 means I/O and 0 means RAM.
- R11: `ram_sel`, `io_sel` and the translated outputs do not depend on `phi2` or `rd_wr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 10 | Processor address A9..A0 |
| rom_sel_n | input | 1 | Active-low ROM region select |
| cs_n | input | 1 | Active-low chip select shared with the adapter |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | Bus clock phase; high = this processor's phase |
| rom_en | output | 1 | ROM access enable |
| rom_oe | output | 1 | ROM data drive enable |
| ram_sel | output | 1 | RAM select |
| io_sel | output | 1 | I/O and timer register select |
| xlat_addr | output | 7 | Re-mapped address for the substitute device |
| xlat_cs_hi | output | 1 | Active-high chip select for the substitute device |
| xlat_io_mode | output | 1 | Substitute device RAM/I/O select |

## Verification
Every address is applied under all sixteen combinations of the two select pins, the read/write line and the clock phase. The sweep runs against the default variant and against a variant with both parameters flipped. The pin combinations separate ROM selection from RAM and I/O selection, and show that writes and the low clock phase suppress ROM drive. The address sweep shows the exact boundaries of each window, the A6 hole with 0x1FF inside it, the page-two and page-three RAM mirrors and the I/O mirrors present only in the alternate variant. Each vector also checks that the selects are mutually exclusive.

// File: rtl/periph_addr_decoder.sv
module periph_addr_decoder #(
  parameter bit RAM_USE_A9     = 1'b1,
  parameter bit IO_FULL_DECODE = 1'b1,
  parameter int AW             = 10,
  parameter int XW             = 7
) (
  input  logic [AW-1:0] addr,
  input  logic          rom_sel_n,
  input  logic          cs_n,
  input  logic          rd_wr_n,
  input  logic          phi2,
  output logic          rom_en,
  output logic          rom_oe,
  output logic          ram_sel,
  output logic          io_sel,
  output logic [XW-1:0] xlat_addr,
  output logic          xlat_cs_hi,
  output logic          xlat_io_mode
);

  logic low_page;
  logic ram_a9_ok;
  logic io_window;

  assign rom_en = ~rom_sel_n & cs_n & rd_wr_n;
  assign rom_oe = rom_en & phi2;

  assign low_page  = ~cs_n & ~addr[6];
  assign ram_a9_ok = RAM_USE_A9 ? ~addr[9] : 1'b1;
  assign ram_sel   = rom_sel_n & low_page & ~addr[7] & ram_a9_ok;

  generate
    if (IO_FULL_DECODE) begin : g_io_full
      assign io_window = ~|{addr[9:8], addr[5:4]};
    end else begin : g_io_mirror
      assign io_window = ~|addr[9:8];
    end
  endgenerate

  assign io_sel = low_page & addr[7] & io_window;

  assign xlat_addr    = {1'b0, addr[5], addr[4] | addr[7], addr[3:0]};
  assign xlat_cs_hi   = ~addr[6];
  assign xlat_io_mode = addr[7];

  always_comb begin
    a_r9_one_select: assert ($onehot0({rom_en, ram_sel, io_sel}));
    if (addr[6]) begin
      a_r8_adapter_hole: assert (!ram_sel && !io_sel);
    end
    if (!rd_wr_n) begin
      a_r3_no_rom_write: assert (!rom_en && !rom_oe);
    end
    if (!phi2) begin
      a_r2_phase_gate: assert (!rom_oe);
    end
    if (addr == AW'(10'h1FF)) begin
      a_r8_stack_top: assert (!ram_sel);
    end
    if (cs_n) begin
      a_r4_cs_needed: assert (!ram_sel && !io_sel);
    end
  end

endmodule

// File: tb/test_periph_addr_decoder.sv
module test_periph_addr_decoder;

  logic       clk = 1'b0;
  logic [9:0] addr = '0;
  logic       rom_sel_n = 1'b1, cs_n = 1'b1, rd_wr_n = 1'b1, phi2 = 1'b0;

  logic       d_rom, d_oe, d_ram, d_io, d_cs1, d_rs;
  logic [6:0] d_xa;
  logic       a_rom, a_oe, a_ram, a_io, a_cs1, a_rs;
  logic [6:0] a_xa;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [9:0] a;
    logic       rom, oe, ram_d, ram_a, io_d, io_a;
    logic [6:0] xa;
    logic       cs1, rs;
  } exp_t;

  exp_t q[$];

  always #2.5 clk = ~clk;

  periph_addr_decoder i_periph_addr_decoder (
    .addr(addr), .rom_sel_n(rom_sel_n), .cs_n(cs_n), .rd_wr_n(rd_wr_n), .phi2(phi2),
    .rom_en(d_rom), .rom_oe(d_oe), .ram_sel(d_ram), .io_sel(d_io),
    .xlat_addr(d_xa), .xlat_cs_hi(d_cs1), .xlat_io_mode(d_rs));

  periph_addr_decoder #(.RAM_USE_A9(1'b0), .IO_FULL_DECODE(1'b0)) i_periph_addr_decoder_alt (
    .addr(addr), .rom_sel_n(rom_sel_n), .cs_n(cs_n), .rd_wr_n(rd_wr_n), .phi2(phi2),
    .rom_en(a_rom), .rom_oe(a_oe), .ram_sel(a_ram), .io_sel(a_io),
    .xlat_addr(a_xa), .xlat_cs_hi(a_cs1), .xlat_io_mode(a_rs));

  task automatic check(string req, logic [9:0] a, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, act, exp);
    end
  endtask

  task automatic drive(logic [9:0] a, logic rs, logic cs, logic rw, logic ph);
    exp_t e;
    int v;
    @(posedge clk);
    addr = a; rom_sel_n = rs; cs_n = cs; rd_wr_n = rw; phi2 = ph;
    v = int'(a);
    e.a     = a;
    e.rom   = !rs && cs && rw;
    e.oe    = e.rom && ph;
    e.ram_d = rs && !cs && ((v <= 'h03F) || (v >= 'h100 && v <= 'h13F));
    e.ram_a = rs && !cs && ((v % 256) <= 'h03F);
    e.io_d  = !cs && v >= 'h080 && v <= 'h08F;
    e.io_a  = !cs && v >= 'h080 && v <= 'h0BF;
    e.xa    = {1'b0, a[5], a[4] | a[7], a[3:0]};
    e.cs1   = !a[6];
    e.rs    = a[7];
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        e = q.pop_front();
        check("R1", e.a, d_rom, e.rom);
        check("R1", e.a, a_rom, e.rom);
        check("R2", e.a, d_oe, e.oe);
        check("R2", e.a, a_oe, e.oe);
        if (!rd_wr_n) check("R3", e.a, d_rom | d_oe | a_rom | a_oe, 0);
        check("R4", e.a, d_ram, e.ram_d);
        check("R5", e.a, a_ram, e.ram_a);
        check("R6", e.a, d_io, e.io_d);
        check("R7", e.a, a_io, e.io_a);
        if (e.a[6]) check("R8", e.a, d_ram | d_io | a_ram | a_io, 0);
        check("R9", e.a, int'(d_rom) + int'(d_ram) + int'(d_io) <= 1, 1);
        check("R9", e.a, int'(a_rom) + int'(a_ram) + int'(a_io) <= 1, 1);
        check("R10", e.a, {d_xa, d_cs1, d_rs}, {e.xa, e.cs1, e.rs});
        check("R11", e.a, {a_xa, a_cs1, a_rs}, {e.xa, e.cs1, e.rs});
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stimulus
    // Idle state: nothing selected with both selects inactive
    drive(10'h000, 1'b1, 1'b1, 1'b1, 1'b0);
    // Key corners: ROM read/write, stack top, adapter hole, I/O mirror
    drive(10'h3FF, 1'b0, 1'b1, 1'b1, 1'b1);
    drive(10'h3FF, 1'b0, 1'b1, 1'b0, 1'b1);
    drive(10'h1FF, 1'b1, 1'b0, 1'b1, 1'b1);
    drive(10'h13F, 1'b1, 1'b0, 1'b0, 1'b0);
    drive(10'h040, 1'b1, 1'b0, 1'b1, 1'b1);
    drive(10'h090, 1'b1, 1'b0, 1'b1, 1'b1);
    drive(10'h23F, 1'b1, 1'b0, 1'b1, 1'b1);
    for (int m = 0; m < 16; m++) begin
      for (int a = 0; a < 1024; a++) begin
        drive(10'(a), m[3], m[2], m[1], m[0]);
      end
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule